// File: doc/BRIEF.md
# Row-Buffered DRAM Access Controller

This controller sits between a CPU-side request port and a DRAM array. In front of the array it keeps one buffer that holds a whole row. Every read is answered from that buffer. A read to the buffered row (a page hit) is answered after one register stage and never touches the array. A read to any other row first copies the whole addressed row into the buffer in one wide transfer. The requested word is then returned as part of that same longer access, and the buffer's row tag is updated.

Writes go through to the array. Each write is held in a one-entry posted-write slot and retires to the array when the array is free. A write to the buffered row also updates the buffer word in the same cycle, so the buffer never holds stale data. A write to any other row leaves the buffer and its tag alone.

An interval timer raises refresh requests. Refresh uses only the array, so page hits continue while it runs. When a refresh and a read miss both want the array, the miss goes first unless the refresh has waited past an overdue threshold. The array model included here is synthesizable and scaled down, with configurable latencies and a row-wide read bus.

Top module: `rowbuf_dram_ctrl`

## Requirements
- R1: After reset, rsp_valid is low and req_ready is high. The buffer is marked empty, so the first read after reset reports rsp_hit=0.
- R2: A read to the buffered row is accepted whenever no miss is in progress, even while a posted write or a refresh occupies the array. Its rsp_valid is high with rsp_hit=1 in the cycle right after the accepting edge.
- R3: A read miss loads the whole addressed row and answers with rsp_hit=0. Later reads of any column of that row hit, until another read miss occurs.
- R4: Read data always equals the most recent value written to that row and column, including a write that hit the buffer.
- R5: Every write reaches the array, whether it hits or misses. A write miss changes neither the buffered row nor its tag, so a later read of the buffered row still hits.
- R6: The posted-write slot holds one write. While it is occupied, a new write sees req_ready low.
- R7: While a posted write has not yet retired, a read miss sees req_ready low.
- R8: A read miss answers no earlier than MISS_LAT+2 cycles and no later than MISS_LAT+WR_LAT+2*REF_LAT+4 cycles after its accepting edge.
- R9: The timer raises a refresh request every REF_INTERVAL cycles. A refresh is granted ahead of a waiting read miss only once it has been pending REF_OVERDUE cycles. A pending refresh is always served within a bounded time.
- R10: Each accepted read produces exactly one response, and no response appears without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Row address |
| req_col | input | $clog2(COLS) | Column (word) address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_hit | output | 1 | 1 = served from buffered row, 0 = row was reloaded |
| rsp_rdata | output | DW | Read data |

## Verification
The assertions assume the requester keeps req_row, req_col, req_we and req_wdata steady in any cycle where req_valid is high. They also assume that only the controller drives the array. The bench changes request fields only at falling clock edges, and every probe of req_ready drops req_valid before the next rising edge, so no request is accepted that the model has not recorded. Latency limits assume default latencies no smaller than one cycle. The stimulus includes idle stretches long enough for refreshes to become pending and overdue while reads are in flight.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_RDROW   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_REFRESH = 2'd3
  } arr_op_e;

  typedef enum logic [1:0] {
    S_IDLE      = 2'd0,
    S_MISS_REQ  = 2'd1,
    S_MISS_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/rowbuf_dram_array.sv
module rowbuf_dram_array
  import rowbuf_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 8,
  parameter int DW     = 32,
  parameter int RD_LAT = 4,
  parameter int WR_LAT = 3,
  parameter int RF_LAT = 3,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int MAXL  = (RD_LAT > WR_LAT) ? ((RD_LAT > RF_LAT) ? RD_LAT : RF_LAT)
                                           : ((WR_LAT > RF_LAT) ? WR_LAT : RF_LAT),
  localparam int LW    = $clog2(MAXL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  arr_op_e            cmd_op,
  input  logic [RW-1:0]      cmd_row,
  input  logic [CW-1:0]      cmd_col,
  input  logic [DW-1:0]      cmd_wdata,
  output logic               busy,
  output logic               rd_done,
  output logic [COLS*DW-1:0] row_data
);
  logic [COLS*DW-1:0] mem [ROWS];
  logic [LW-1:0]      cnt;
  arr_op_e            op_q;
  logic [RW-1:0]      row_q;
  logic               accept;
  logic               finish;

  assign accept = cmd_valid && !busy;
  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      op_q    <= OP_NONE;
      row_q   <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        op_q  <= cmd_op;
        row_q <= cmd_row;
        case (cmd_op)
          OP_RDROW: cnt <= LW'(RD_LAT - 1);
          OP_WRITE: cnt <= LW'(WR_LAT - 1);
          default:  cnt <= LW'(RF_LAT - 1);
        endcase
      end else if (finish) begin
        busy    <= 1'b0;
        rd_done <= (op_q == OP_RDROW);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // storage: one word write port, one row-wide read port
  always_ff @(posedge clk) begin
    if (accept && cmd_op == OP_WRITE)
      mem[cmd_row][cmd_col*DW +: DW] <= cmd_wdata;
  end

  always_ff @(posedge clk) begin
    if (finish && op_q == OP_RDROW)
      row_data <= mem[row_q];
  end
endmodule

// File: rtl/rowbuf_refresh_sched.sv
module rowbuf_refresh_sched #(
  parameter int ROWS         = 16,
  parameter int INTERVAL     = 40,
  parameter int OVERDUE      = 20,
  localparam int RW          = $clog2(ROWS),
  localparam int TW          = $clog2(INTERVAL),
  localparam int AW          = $clog2(OVERDUE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  output logic          pending,
  output logic          overdue,
  output logic [RW-1:0] ref_row
);
  logic [TW-1:0] tmr;
  logic [AW-1:0] age;
  logic          tick;

  assign tick    = (tmr == TW'(INTERVAL - 1));
  assign overdue = pending && (age == AW'(OVERDUE));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      age     <= '0;
      pending <= 1'b0;
      ref_row <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (grant) begin
        pending <= 1'b0;
        age     <= '0;
        ref_row <= ref_row + 1'b1;
      end else if (pending && age != AW'(OVERDUE)) begin
        age <= age + 1'b1;
      end
      if (tick)
        pending <= 1'b1;
    end
  end
endmodule

// File: rtl/rowbuf_line.sv
module rowbuf_line #(
  parameter int COLS = 8,
  parameter int DW   = 32,
  localparam int CW  = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               load,
  input  logic [COLS*DW-1:0] load_data,
  input  logic               wr_en,
  input  logic [CW-1:0]      wr_col,
  input  logic [DW-1:0]      wr_data,
  input  logic [CW-1:0]      rd_col,
  output logic [DW-1:0]      rd_data
);
  logic [DW-1:0] words [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_word
    always_ff @(posedge clk) begin
      if (load)
        words[c] <= load_data[c*DW +: DW];
      else if (wr_en && wr_col == CW'(c))
        words[c] <= wr_data;
    end
  end

  assign rd_data = words[rd_col];
endmodule

// File: rtl/rowbuf_dram_ctrl.sv
module rowbuf_dram_ctrl
  import rowbuf_pkg::*;
#(
  parameter int ROWS         = 16,
  parameter int COLS         = 8,
  parameter int DW           = 32,
  parameter int MISS_LAT     = 4,
  parameter int WR_LAT       = 3,
  parameter int REF_LAT      = 3,
  parameter int REF_INTERVAL = 40,
  parameter int REF_OVERDUE  = 20,
  localparam int RW          = $clog2(ROWS),
  localparam int CW          = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_rdata
);
  ctl_state_e         state;
  logic               buf_valid;
  logic [RW-1:0]      last_row;
  logic [RW-1:0]      miss_row;
  logic [CW-1:0]      miss_col;
  logic               wr_pending;
  logic [RW-1:0]      wr_row;
  logic [CW-1:0]      wr_col;
  logic [DW-1:0]      wr_data;
  logic               page_hit;
  logic               accept;
  logic [DW-1:0]      buf_word;
  arr_op_e            issue_op;
  logic               arr_busy;
  logic               arr_rd_done;
  logic [COLS*DW-1:0] arr_row;
  logic [RW-1:0]      cmd_row;
  logic               ref_pend;
  logic               ref_overdue;
  logic               ref_grant;
  logic [RW-1:0]      ref_row;
  logic               miss_load;

  assign page_hit  = buf_valid && (req_row == last_row);
  assign req_ready = (state == S_IDLE) && (req_we ? !wr_pending : (page_hit || !wr_pending));
  assign accept    = req_valid && req_ready;
  assign miss_load = (state == S_MISS_WAIT) && arr_rd_done;

  // array arbitration: overdue refresh, then posted write, then miss, then refresh
  always_comb begin
    issue_op = OP_NONE;
    if (!arr_busy) begin
      if (ref_pend && ref_overdue)   issue_op = OP_REFRESH;
      else if (wr_pending)           issue_op = OP_WRITE;
      else if (state == S_MISS_REQ)  issue_op = OP_RDROW;
      else if (ref_pend)             issue_op = OP_REFRESH;
    end
  end

  always_comb begin
    case (issue_op)
      OP_WRITE: cmd_row = wr_row;
      OP_RDROW: cmd_row = miss_row;
      default:  cmd_row = ref_row;
    endcase
  end

  assign ref_grant = (issue_op == OP_REFRESH);

  rowbuf_dram_array #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW),
    .RD_LAT(MISS_LAT), .WR_LAT(WR_LAT), .RF_LAT(REF_LAT)
  ) u_array (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (issue_op != OP_NONE),
    .cmd_op    (issue_op),
    .cmd_row   (cmd_row),
    .cmd_col   (wr_col),
    .cmd_wdata (wr_data),
    .busy      (arr_busy),
    .rd_done   (arr_rd_done),
    .row_data  (arr_row)
  );

  rowbuf_refresh_sched #(
    .ROWS(ROWS), .INTERVAL(REF_INTERVAL), .OVERDUE(REF_OVERDUE)
  ) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .grant   (ref_grant),
    .pending (ref_pend),
    .overdue (ref_overdue),
    .ref_row (ref_row)
  );

  rowbuf_line #(.COLS(COLS), .DW(DW)) u_line (
    .clk       (clk),
    .load      (miss_load),
    .load_data (arr_row),
    .wr_en     (accept && req_we && page_hit),
    .wr_col    (req_col),
    .wr_data   (req_wdata),
    .rd_col    (req_col),
    .rd_data   (buf_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      buf_valid  <= 1'b0;
      last_row   <= '0;
      miss_row   <= '0;
      miss_col   <= '0;
      wr_pending <= 1'b0;
      wr_row     <= '0;
      wr_col     <= '0;
      wr_data    <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (issue_op == OP_WRITE)
        wr_pending <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (req_we) begin
              wr_pending <= 1'b1;
              wr_row     <= req_row;
              wr_col     <= req_col;
              wr_data    <= req_wdata;
            end else if (page_hit) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
              rsp_rdata <= buf_word;
            end else begin
              miss_row <= req_row;
              miss_col <= req_col;
              state    <= S_MISS_REQ;
            end
          end
        end
        S_MISS_REQ: begin
          if (issue_op == OP_RDROW)
            state <= S_MISS_WAIT;
        end
        S_MISS_WAIT: begin
          if (arr_rd_done) begin
            buf_valid <= 1'b1;
            last_row  <= miss_row;
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_rdata <= arr_row[miss_col*DW +: DW];
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rowbuf_dram_ctrl_chk.sv
module rowbuf_dram_ctrl_chk
  import rowbuf_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter int MISS_LAT    = 4,
  parameter int WR_LAT      = 3,
  parameter int REF_LAT     = 3,
  parameter int REF_OVERDUE = 20,
  localparam int RW         = $clog2(ROWS),
  localparam int AGE_MAX    = REF_OVERDUE + MISS_LAT + WR_LAT + REF_LAT + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_we,
  input logic [RW-1:0] req_row,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input ctl_state_e    state,
  input logic          buf_valid,
  input logic [RW-1:0] last_row,
  input logic [RW-1:0] miss_row,
  input logic          wr_pending,
  input logic          ref_pend,
  input logic          ref_overdue,
  input logic          ref_grant,
  input logic          arr_rd_done
);
  int unsigned ref_age;

  always_ff @(posedge clk) begin
    if (rst)           ref_age <= 0;
    else if (ref_pend) ref_age <= ref_age + 1;
    else               ref_age <= 0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && req_ready));

  a_r2_hit_reply: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_we && buf_valid && req_row == last_row) |=> (rsp_valid && rsp_hit));

  a_r2_hit_open: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !req_we && buf_valid && req_row == last_row) |-> req_ready);

  a_r3_tag_load: assert property (@(posedge clk) disable iff (rst)
    (state == S_MISS_WAIT && arr_rd_done) |=> (buf_valid && last_row == $past(miss_row) && rsp_valid && !rsp_hit));

  a_r5_write_keeps_tag: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_we) |=> ($stable(last_row) && $stable(buf_valid)));

  a_r6_single_post: assert property (@(posedge clk) disable iff (rst)
    (wr_pending && req_we) |-> !req_ready);

  a_r7_miss_waits_post: assert property (@(posedge clk) disable iff (rst)
    (wr_pending && !req_we && !(buf_valid && req_row == last_row)) |-> !req_ready);

  a_r9_miss_first: assert property (@(posedge clk) disable iff (rst)
    (ref_grant && state == S_MISS_REQ) |-> ref_overdue);

  a_r9_refresh_served: assert property (@(posedge clk) disable iff (rst)
    ref_age <= AGE_MAX);

  a_r10_miss_reply_source: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(state == S_MISS_WAIT));
endmodule

bind rowbuf_dram_ctrl rowbuf_dram_ctrl_chk #(
  .ROWS(ROWS), .MISS_LAT(MISS_LAT), .WR_LAT(WR_LAT),
  .REF_LAT(REF_LAT), .REF_OVERDUE(REF_OVERDUE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_we      (req_we),
  .req_row     (req_row),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .state       (state),
  .buf_valid   (buf_valid),
  .last_row    (last_row),
  .miss_row    (miss_row),
  .wr_pending  (wr_pending),
  .ref_pend    (ref_pend),
  .ref_overdue (ref_overdue),
  .ref_grant   (ref_grant),
  .arr_rd_done (arr_rd_done)
);

// File: tb/rowbuf_dram_ctrl_test.sv
`timescale 1ns/1ps
module rowbuf_dram_ctrl_test;
  localparam int ROWS    = 16;
  localparam int COLS    = 8;
  localparam int MISS    = 4;
  localparam int WRL     = 3;
  localparam int REFL    = 3;
  localparam int MIN_MISS = MISS + 2;
  localparam int MAX_MISS = MISS + WRL + 2 * REFL + 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [3:0]  req_row = '0;
  logic [2:0]  req_col = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  // behavioural reference
  logic [31:0] mem_m [int];
  int          tag_m = -1;
  logic [31:0] q_data [$];
  bit          q_hit  [$];
  int          q_acc  [$];

  rowbuf_dram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int misses_out();
    int n = 0;
    foreach (q_hit[i]) if (!q_hit[i]) n++;
    return n;
  endfunction

  // response monitor, compared every clock
  always @(negedge clk) begin
    if (!rst && !ended) begin
      if (rsp_valid) begin
        if (q_data.size() == 0) begin
          check(0, "R10 response without read", 1, 0);
        end else begin
          automatic logic [31:0] d = q_data.pop_front();
          automatic bit          h = q_hit.pop_front();
          automatic int          a = q_acc.pop_front();
          check(rsp_rdata === d, "R4 read data", rsp_rdata, d);
          check(rsp_hit === h, "R1/R3 hit flag", rsp_hit, h);
          if (h) check(cyc == a, "R2 hit latency", cyc - a, 0);
          else   check(cyc - a >= MIN_MISS && cyc - a <= MAX_MISS, "R8 miss latency", cyc - a, MIN_MISS);
        end
      end else if (q_acc.size() > 0 && (cyc - q_acc[0]) > MAX_MISS) begin
        check(0, "R10 missing response", cyc - q_acc[0], MAX_MISS);
        void'(q_data.pop_front()); void'(q_hit.pop_front()); void'(q_acc.pop_front());
      end
    end
  end

  task automatic issue(input bit we, input int row, input int col, input logic [31:0] d);
    automatic int  key = row * COLS + col;
    automatic bit  hp  = (tag_m == row);
    @(negedge clk);
    req_valid = 1; req_we = we; req_row = 4'(row); req_col = 3'(col); req_wdata = d;
    #1;
    if (!we && hp && misses_out() == 0)
      check(req_ready === 1'b1, "R2 hit accepted at once", req_ready, 1);
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    if (we) mem_m[key] = d;
    else begin
      q_data.push_back(mem_m[key]);
      q_hit.push_back(hp);
      q_acc.push_back(cyc + 1);
      if (!hp) tag_m = row;
    end
    @(posedge clk);
  endtask

  task automatic probe(input bit we, input int row, input int col, input bit exp, input string req);
    @(negedge clk);
    req_valid = 1; req_we = we; req_row = 4'(row); req_col = 3'(col); req_wdata = 32'h0;
    #1;
    check(req_ready === exp, req, req_ready, exp);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    @(negedge clk); req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(1);
    for (int i = 0; i < 100 && q_acc.size() > 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk); #1;
    check(rsp_valid === 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
    check(req_ready === 1'b1, "R1 reset req_ready", req_ready, 1);

    // fill the array; all writes miss (buffer empty after reset) - R5
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        issue(1, r, c, {8'hA0, 8'(r), 8'(c), 8'h5C});

    // R1: first read after reset misses; R3: rest of the row hits
    issue(0, 2, 3, 0);
    for (int c = 0; c < COLS; c++) issue(0, 2, c, 0);
    drain();

    // R4: write hit keeps buffer coherent
    issue(1, 2, 5, 32'hDEAD_0205);
    issue(0, 2, 5, 0);
    drain();

    // R5: write miss leaves buffered row, array still updated
    issue(1, 9, 1, 32'hBEEF_0901);
    issue(0, 2, 1, 0);
    issue(0, 9, 1, 0);
    drain();

    // R6: second write while slot full
    issue(1, 9, 2, 32'h1111_0902);
    probe(1, 9, 3, 0, "R6 write blocked by posted write");
    idle(10);
    // R7: read miss blocked by posted write; R2 hit still accepted
    issue(1, 3, 0, 32'h2222_0300);
    probe(0, 4, 0, 0, "R7 miss blocked by posted write");
    idle(10);
    issue(1, 3, 1, 32'h3333_0301);
    probe(0, 9, 0, 1, "R2 hit open during posted write");
    idle(10);
    issue(0, 9, 2, 0);
    drain();

    // R9: let refresh become due, then hits and misses race it
    for (int k = 0; k < 4; k++) begin
      idle(35 + 7 * k);
      issue(0, k, 0, 0);
      for (int j = 0; j < 12; j++) issue(0, k, j % COLS, 0);
    end
    drain();

    // mixed traffic over a few rows
    for (int i = 0; i < 600; i++) begin
      automatic int r  = $urandom_range(0, 3);
      automatic int c  = $urandom_range(0, COLS - 1);
      automatic bit we = ($urandom_range(0, 3) == 0);
      issue(we, r, c, $urandom);
      if ($urandom_range(0, 15) == 0) idle($urandom_range(1, 30));
    end
    drain();
    check(q_acc.size() == 0, "R10 all reads answered", q_acc.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end
endmodule